// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block recovers frames from an asynchronous serial line. An oversampling enable, pulsed at sixteen times the bit rate by a baud generator outside the block, paces a sampler. The sampler resynchronises the line, confirms a start bit at mid-bit and then takes the data bits least significant first. It can also take a parity bit, and it checks the stop bit. Frames carry eight data bits, or nine when the extended mode is selected.

When a frame completes, its low eight bits go to a receive buffer. In the same cycle the block raises a one-cycle completion pulse and updates a status byte. The status byte holds a receive-busy flag, the ninth data bit, and the parity, framing and overrun errors. A read strobe on the buffer clears the three error flags. If a frame completes while the buffer is still unread, the new frame overwrites the buffer and an overrun is reported.

Top module: `uart_rx_status`

## Requirements
- R1: `stat_busy` rises once a falling edge of the line has been seen at an oversampling enable, and it reads 0 in the cycle where `rx_done` is high.
- R2: With `ext9_en`=1 a frame has nine data bits. The ninth bit appears on `stat_bit9` and the low eight appear on `rx_data`. With `ext9_en`=0, `stat_bit9` reads 0 after each frame.
- R3: With `par_mode`=2'b10 (odd), the data bits and the parity bit must together hold an odd number of ones. With 2'b11 (even), the count must be even. A mismatch sets `stat_perr` with that frame.
- R4: With `par_mode`=2'b00 the frame has no parity slot. With 2'b01 the frame has a parity slot whose value is ignored. In both modes `stat_perr` is never set by a frame.
- R5: A low line at the stop-bit sampling point sets `stat_ferr` with that frame.
- R6: A frame that completes while the previous frame is unread, with no read in that cycle, sets `stat_ovr`. The new data replaces the old data in `rx_data`.
- R7: A `buf_rd` pulse clears `stat_perr`, `stat_ferr` and `stat_ovr` from the next cycle. If a frame completes in the same cycle, the flags take the new frame's values.
- R8: After reset, `status` is 8'h00, `rx_data` is 8'h00 and `rx_done` is 0.
- R9: A start bit that is high at its mid-bit check is dropped. No `rx_done` follows, and `stat_busy` returns to 0.
- R10: `rx_done` is high for exactly one cycle per frame. `rx_data` and the error flags take their new values in that same cycle. Data bits are received least significant bit first.
- R11: The `status` byte is laid out as bit0 = parity error, bit1 = framing error, bit2 = overrun, bit3 = busy, bit4 = ninth bit, and bits 7..5 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| ext9_en | input | 1 | Select nine data bits per frame |
| par_mode | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| buf_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer |
| rx_done | output | 1 | One-cycle frame completion pulse |
| stat_busy | output | 1 | Frame reception in progress |
| stat_bit9 | output | 1 | Ninth data bit of the last frame |
| stat_perr | output | 1 | Parity error flag |
| stat_ferr | output | 1 | Framing error flag |
| stat_ovr | output | 1 | Overrun error flag |
| status | output | 8 | Status byte, layout as in R11 |

## Verification
The line passes through two synchronising flops, so each result arrives a few cycles after the stimulus. The completion pulse, the buffer contents and the error flags appear together about two cycles after the stop-bit midpoint reaches the input. The monitor therefore waits for `rx_done` rather than counting cycles, and it compares the whole expected frame in that cycle. Busy is checked half a bit time after the start edge, and the glitch outcome is checked two bit times later. A read strobe clears the flags one cycle later, and the bench samples them one full cycle after the strobe. All sampling happens on the falling clock edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'b00,
    PM_ZERO = 2'b01,
    PM_ODD  = 2'b10,
    PM_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [8:0] data;
    logic       perr;
    logic       ferr;
  } frame_res_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d_in;
    if (g == 0) begin : g_first
      assign d_in = din;
    end else begin : g_rest
      assign d_in = sr_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q[g] <= 1'b1;
      else        sr_q[g] <= d_in;
    end
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_s,
  input  logic       os_tick,
  input  logic       ext9_en,
  input  logic [1:0] par_mode,
  output logic       busy,
  output logic       frame_done,
  output frame_res_t res
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       idx_q, idx_d;
  logic [8:0]       shr_q, shr_d;
  logic             pbit_q, pbit_d;
  logic [3:0]       last_idx;
  logic [8:0]       data_eff;
  logic             ones_x;

  assign last_idx = ext9_en ? 4'd8 : 4'd7;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    shr_d      = shr_q;
    pbit_d     = pbit_q;
    frame_done = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        idx_d = '0;
        if (os_tick && !line_s) begin
          state_d = ST_START;
          shr_d   = '0;
        end
      end
      ST_START: if (os_tick) begin
        if (cnt_q == MID_CNT) begin
          cnt_d   = '0;
          state_d = line_s ? ST_IDLE : ST_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: if (os_tick) begin
        if (cnt_q == LAST_CNT) begin
          cnt_d        = '0;
          shr_d[idx_q] = line_s;
          if (idx_q == last_idx) begin
            state_d = (par_mode == PM_NONE) ? ST_STOP : ST_PAR;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR: if (os_tick) begin
        if (cnt_q == LAST_CNT) begin
          cnt_d   = '0;
          pbit_d  = line_s;
          state_d = ST_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: if (os_tick) begin
        if (cnt_q == LAST_CNT) begin
          cnt_d      = '0;
          frame_done = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
      pbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      pbit_q  <= pbit_d;
    end
  end

  assign data_eff = {shr_q[8] & ext9_en, shr_q[7:0]};
  assign ones_x   = (^data_eff) ^ pbit_q;
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    res.data = data_eff;
    res.ferr = ~line_s;
    case (par_mode)
      PM_ODD:  res.perr = ~ones_x;
      PM_EVEN: res.perr = ones_x;
      default: res.perr = 1'b0;
    endcase
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && os_tick && !line_s) |=> busy) else $error("busy"); // R1
  AST_PERR_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !par_mode[1]) |-> !res.perr) else $error("perr"); // R4
  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && os_tick && cnt_q == MID_CNT && line_s) |=> !busy) else $error("glitch"); // R9
endmodule

// File: rtl/rx_status_buf.sv
module rx_status_buf
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  frame_res_t res,
  input  logic       buf_rd,
  output logic [7:0] rx_data,
  output logic       rx_done,
  output logic       bit9,
  output logic       perr,
  output logic       ferr,
  output logic       ovr
);
  logic [7:0] data_q, data_d;
  logic       bit9_q, bit9_d;
  logic       perr_q, perr_d;
  logic       ferr_q, ferr_d;
  logic       ovr_q, ovr_d;
  logic       unread_q, unread_d;
  logic       done_q;
  logic       ovr_new;

  assign ovr_new = unread_q & ~buf_rd;

  always_comb begin
    data_d   = data_q;
    bit9_d   = bit9_q;
    perr_d   = perr_q;
    ferr_d   = ferr_q;
    ovr_d    = ovr_q;
    unread_d = unread_q;
    if (frame_done) begin
      data_d   = res.data[7:0];
      bit9_d   = res.data[8];
      perr_d   = (perr_q & ~buf_rd) | res.perr;
      ferr_d   = (ferr_q & ~buf_rd) | res.ferr;
      ovr_d    = (ovr_q  & ~buf_rd) | ovr_new;
      unread_d = 1'b1;
    end else if (buf_rd) begin
      perr_d   = 1'b0;
      ferr_d   = 1'b0;
      ovr_d    = 1'b0;
      unread_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      bit9_q   <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      ovr_q    <= 1'b0;
      unread_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      data_q   <= data_d;
      bit9_q   <= bit9_d;
      perr_q   <= perr_d;
      ferr_q   <= ferr_d;
      ovr_q    <= ovr_d;
      unread_q <= unread_d;
      done_q   <= frame_done;
    end
  end

  assign rx_data = data_q;
  assign rx_done = done_q;
  assign bit9    = bit9_q;
  assign perr    = perr_q;
  assign ferr    = ferr_q;
  assign ovr     = ovr_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done) else $error("done width"); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !frame_done) |=> (!perr && !ferr && !ovr)) else $error("clear"); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && unread_q && !buf_rd) |=> ovr) else $error("ovr"); // R6
  AST_FERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && res.ferr) |=> ferr) else $error("ferr"); // R5
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic       ext9_en,
  input  logic [1:0] par_mode,
  input  logic       buf_rd,
  output logic [7:0] rx_data,
  output logic       rx_done,
  output logic       stat_busy,
  output logic       stat_bit9,
  output logic       stat_perr,
  output logic       stat_ferr,
  output logic       stat_ovr,
  output logic [7:0] status
);
  logic       line_s;
  logic       frame_done;
  frame_res_t res;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  rx_frame_fsm #(.OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .os_tick(os_tick),
    .ext9_en(ext9_en), .par_mode(par_mode), .busy(stat_busy),
    .frame_done(frame_done), .res(res)
  );

  rx_status_buf u_stat (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .res(res),
    .buf_rd(buf_rd), .rx_data(rx_data), .rx_done(rx_done),
    .bit9(stat_bit9), .perr(stat_perr), .ferr(stat_ferr), .ovr(stat_ovr)
  );

  assign status = {3'b000, stat_bit9, stat_busy, stat_ovr, stat_ferr, stat_perr};

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !stat_busy) else $error("busy at done"); // R1
  AST_BIT9_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ext9_en) |=> !stat_bit9) else $error("bit9"); // R2
endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  localparam int BIT_CLKS = 64;

  typedef struct {
    logic [8:0] data;
    logic       p, f, o;
    string      tag;
  } exp_t;

  logic clk, rst_n, rx_line, os_tick, ext9_en, buf_rd;
  logic [1:0] par_mode;
  logic [7:0] rx_data, status;
  logic rx_done, stat_busy, stat_bit9, stat_perr, stat_ferr, stat_ovr;

  int n_chk = 0;
  int n_bad = 0;
  exp_t q[$];
  logic mp = 0, mf = 0, mo = 0, unread_m = 0;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .ext9_en(ext9_en), .par_mode(par_mode), .buf_rd(buf_rd),
    .rx_data(rx_data), .rx_done(rx_done), .stat_busy(stat_busy),
    .stat_bit9(stat_bit9), .stat_perr(stat_perr), .stat_ferr(stat_ferr),
    .stat_ovr(stat_ovr), .status(status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: compare each completed frame against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rx_done === 1'b1) begin
        if (q.size() == 0) begin
          check("R9 unexpected frame", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " R10 data"}, rx_data, e.data[7:0]);
          check({e.tag, " R2 bit9"}, stat_bit9, e.data[8]);
          check({e.tag, " R3/R4 perr"}, stat_perr, e.p);
          check({e.tag, " R5 ferr"}, stat_ferr, e.f);
          check({e.tag, " R6 ovr"}, stat_ovr, e.o);
          check({e.tag, " R1 busy at done"}, stat_busy, 0);
          check({e.tag, " R11 status"}, status,
                {3'b000, e.data[8], 1'b0, e.o, e.f, e.p});
        end
      end
    end
  end

  task automatic bit_time(input logic v);
    rx_line = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input string tag, input logic [8:0] d, input logic ext,
                      input logic [1:0] pm, input logic flip, input logic stop_ok);
    exp_t e;
    logic [8:0] dm;
    logic x, pb, perr_e;
    dm = ext ? d : {1'b0, d[7:0]};
    x = ^dm;
    pb = (pm == 2'b10) ? ~x : (pm == 2'b11) ? x : 1'b0;
    pb = pb ^ flip;
    perr_e = flip & pm[1];
    ext9_en = ext;
    par_mode = pm;
    mp = mp | perr_e;
    mf = mf | ~stop_ok;
    mo = mo | unread_m;
    unread_m = 1'b1;
    e.data = dm; e.p = mp; e.f = mf; e.o = mo; e.tag = tag;
    q.push_back(e);
    rx_line = 1'b0;
    repeat (BIT_CLKS/2) @(negedge clk);
    check({tag, " R1 busy mid start"}, stat_busy, 1);
    repeat (BIT_CLKS/2) @(negedge clk);
    for (int i = 0; i < (ext ? 9 : 8); i++) bit_time(dm[i]);
    if (pm != 2'b00) bit_time(pb);
    bit_time(stop_ok);
    bit_time(1'b1);
    bit_time(1'b1);
  endtask

  task automatic read_buf();
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
    @(negedge clk);
    mp = 0; mf = 0; mo = 0; unread_m = 0;
    check("R7 flags cleared", {stat_perr, stat_ferr, stat_ovr}, 3'b000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; ext9_en = 1'b0; par_mode = 2'b00; buf_rd = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 status reset", status, 8'h00);
    check("R8 data reset", rx_data, 8'h00);
    check("R8 done reset", rx_done, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    send("plain", 9'h0A5, 0, 2'b00, 0, 1); read_buf();
    send("lsb", 9'h001, 0, 2'b00, 0, 1); read_buf();
    send("ext9", 9'h13C, 1, 2'b00, 0, 1); read_buf();
    send("odd ok", 9'h037, 0, 2'b10, 0, 1); read_buf();
    send("odd bad", 9'h037, 0, 2'b10, 1, 1); read_buf();
    send("even bad", 9'h1F0, 1, 2'b11, 1, 1); read_buf();
    send("even ok", 9'h0C3, 0, 2'b11, 0, 1); read_buf();
    send("zero slot", 9'h055, 0, 2'b01, 1, 1); read_buf();
    send("narrow bit9", 9'h1FF, 0, 2'b00, 0, 1); read_buf();
    send("framing", 9'h081, 0, 2'b00, 0, 0);
    bit_time(1'b1);
    read_buf();
    send("ovr first", 9'h011, 0, 2'b00, 0, 1);
    send("ovr second", 9'h022, 0, 2'b00, 0, 1);
    read_buf();

    // R9: short low pulse must not start a frame
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    repeat (2*BIT_CLKS) @(negedge clk);
    check("R9 busy after glitch", stat_busy, 0);
    check("R9 no pending frame", q.size(), 0);
    check("R9 buffer kept", rx_data, 8'h22);

    finish_run();
  end
endmodule